// File: doc/BRIEF.md
# DRAM Column Burst Splitter

This block sits between on-chip clients and the command stage of a single 32-bit DRAM channel. A client hands over one read or write request at a time. The request names a 16-byte-aligned start and covers one to four 16-byte units, so at most a 64-byte block. Each 16-byte unit is four 32-bit beats. The splitter turns the request into a sequence of column commands, each either 4 beats or 8 beats long. The client never sees how the request was divided.

A mode input selects whether 8-beat bursts may be used. An 8-beat burst at column c moves the same data as two 4-beat bursts at c and c+4. In 8-beat mode, two units that start at an even unit address are merged into one long command. A unit at an odd unit address, or a single unit left at the end, goes out as a 4-beat command. In 4-beat-only mode, every unit is a separate command. The mode is captured when a request is accepted.

The splitter takes a new request only after the last command of the current one has been accepted downstream. When that last command is accepted, it raises a one-cycle completion pulse.

Top module: `burst_splitter`

## Requirements
- R1: After reset, `cmd_valid` and `done` are 0 and `req_ready` is 1.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the final command has been accepted.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, the command stays valid, and `cmd_col`, `cmd_long` and `cmd_write` hold their values.
- R4: In 4-beat-only mode (`allow_bl8` = 0 at acceptance), a request of N units gives N commands with `cmd_long` = 0. Their columns are 4×`req_unit`, then +4 for each following command.
- R5: In 8-beat mode (`allow_bl8` = 1), a remaining unit at an even unit address, with at least two units left, is issued as one command with `cmd_long` = 1. The column then advances by 8.
- R6: In 8-beat mode, a unit at an odd unit address, or a lone last unit, is issued with `cmd_long` = 0. An 8-beat command never starts at a column whose bit 2 is 1.
- R7: `done` is 1 for exactly one cycle: the cycle in which the final command of a request is accepted (`cmd_valid` and `cmd_ready` both 1).
- R8: Changing `allow_bl8` while a request is being split has no effect on that request's commands.
- R9: Every command of a request carries the request's `req_write` value on `cmd_write`.
- R10: In the cycle after `done`, `req_ready` is 1 and `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allow_bl8 | input | 1 | 1 allows 8-beat commands; sampled at request acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_unit | input | UNIT_AW | Start address in 16-byte units |
| req_len | input | 2 | Number of 16-byte units minus one |
| cmd_valid | output | 1 | Column command offered |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_write | output | 1 | Direction of the command |
| cmd_col | output | UNIT_AW+2 | Column address in 32-bit beats |
| cmd_long | output | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| done | output | 1 | Final command of the request accepted |

## Verification
Some properties are checked on every cycle:
- a stalled command holds steady;
- request acceptance never overlaps an active command;
- a long burst never starts at an odd unit;
- the completion pulse lines up with a downstream handshake, lasts one cycle, and is followed by readiness.

Other behaviour only the directed scenarios can show:
- the exact column sequence and the mix of short and long bursts for each start alignment and length;
- that the mode is captured at acceptance and not followed afterwards;
- that the write flag is carried to every command.

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int UNIT_AW   = 10,
  parameter int MAX_UNITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               allow_bl8,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [UNIT_AW-1:0] req_unit,
  input  logic [1:0]         req_len,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic               cmd_write,
  output logic [UNIT_AW+1:0] cmd_col,
  output logic               cmd_long,
  output logic               done
);
  localparam int CNT_W = $clog2(MAX_UNITS + 1);

  logic               busy;
  logic               mode8;
  logic               wr;
  logic [UNIT_AW-1:0] cur;
  logic [CNT_W-1:0]   left;
  logic [1:0]         step;
  logic               fire;
  logic               last;

  assign cmd_long  = mode8 && !cur[0] && (left >= CNT_W'(2));
  assign step      = cmd_long ? 2'd2 : 2'd1;
  assign fire      = busy && cmd_ready;
  assign last      = (left == CNT_W'(step));
  assign cmd_valid = busy;
  assign req_ready = !busy;
  assign cmd_write = wr;
  assign cmd_col   = {cur, 2'b00};
  assign done      = fire && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      mode8 <= 1'b0;
      wr    <= 1'b0;
      cur   <= '0;
      left  <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy  <= 1'b1;
        mode8 <= allow_bl8;
        wr    <= req_write;
        cur   <= req_unit;
        left  <= CNT_W'(req_len) + CNT_W'(1);
      end
    end else if (fire) begin
      cur  <= cur + UNIT_AW'(step);
      left <= left - CNT_W'(step);
      if (last) busy <= 1'b0;
    end
  end
endmodule

module burst_splitter_chk #(
  parameter int UNIT_AW = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               cmd_write,
  input logic [UNIT_AW+1:0] cmd_col,
  input logic               cmd_long,
  input logic               done
);
  a_r3_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_col) && $stable(cmd_long) && $stable(cmd_write));

  a_r2_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && cmd_valid));

  a_r6_long_even_only: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_long |-> !cmd_col[2]);

  a_r7_done_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_valid && cmd_ready);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready && !cmd_valid);
endmodule

bind burst_splitter burst_splitter_chk #(.UNIT_AW(UNIT_AW)) u_chk (.*);

// File: tb/tb_burst_splitter.sv
module tb_burst_splitter;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          allow_bl8 = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_unit = '0;
  logic [1:0]    req_len = '0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic          cmd_write;
  logic [AW+1:0] cmd_col;
  logic          cmd_long;
  logic          done;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  burst_splitter #(.UNIT_AW(AW), .MAX_UNITS(4)) dut (
    .clk(clk), .rst_n(rst_n), .allow_bl8(allow_bl8),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_unit(req_unit), .req_len(req_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .cmd_long(cmd_long), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 done", int'(done), 0);
  endtask

  task automatic run_req(input bit w, input int unit, input int len, input bit m,
                         input bit stall, input bit flip);
    int  cur;
    int  left;
    int  cyc;
    bit  exp_long;
    bit  exp_last;
    cur  = unit;
    left = len + 1;
    cyc  = 0;
    @(negedge clk);
    allow_bl8 = m;
    req_write = w;
    req_unit  = AW'(unit);
    req_len   = 2'(len);
    req_valid = 1'b1;
    chk("R2 ready before accept", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) allow_bl8 = ~m;
    while (left > 0) begin
      cmd_ready = stall ? cyc[0] : 1'b1;
      #1;
      exp_long = m && (cur % 2 == 0) && (left >= 2);
      exp_last = (left == (exp_long ? 2 : 1));
      chk("R2 ready low while busy", int'(req_ready), 0);
      chk("R3 cmd_valid", int'(cmd_valid), 1);
      chk("R4 cmd_col", int'(cmd_col), cur * 4);
      chk(m ? "R5/R6/R8 cmd_long" : "R4/R8 cmd_long", int'(cmd_long), int'(exp_long));
      chk("R9 cmd_write", int'(cmd_write), int'(w));
      chk("R7 done", int'(done), int'(cmd_ready && exp_last));
      if (cmd_ready) begin
        cur  = cur + (exp_long ? 2 : 1);
        left = left - (exp_long ? 2 : 1);
      end
      cyc++;
      @(negedge clk);
    end
    cmd_ready = 1'b0;
    #1;
    chk("R10 req_ready", int'(req_ready), 1);
    chk("R10 cmd_valid", int'(cmd_valid), 0);
    chk("R7 done low after", int'(done), 0);
  endtask

  task automatic t_mode4_full();      run_req(1'b0, 8, 3, 1'b0, 1'b0, 1'b0); endtask
  task automatic t_mode8_full();      run_req(1'b0, 8, 3, 1'b1, 1'b0, 1'b0); endtask
  task automatic t_mode8_odd_start(); run_req(1'b1, 5, 3, 1'b1, 1'b0, 1'b0); endtask
  task automatic t_mode8_three();     run_req(1'b0, 4, 2, 1'b1, 1'b0, 1'b0); endtask
  task automatic t_mode8_single();    run_req(1'b1, 2, 0, 1'b1, 1'b0, 1'b0); endtask
  task automatic t_stall_write();     run_req(1'b1, 12, 3, 1'b1, 1'b1, 1'b0); endtask
  task automatic t_stall_mode4();     run_req(1'b0, 7, 1, 1'b0, 1'b1, 1'b0); endtask
  task automatic t_flip_8to4();       run_req(1'b0, 16, 3, 1'b1, 1'b0, 1'b1); endtask
  task automatic t_flip_4to8();       run_req(1'b1, 20, 3, 1'b0, 1'b0, 1'b1); endtask
  task automatic t_wrap();            run_req(1'b0, 1022, 3, 1'b1, 1'b0, 1'b0); endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_mode4_full();
    t_mode8_full();
    t_mode8_odd_start();
    t_mode8_three();
    t_mode8_single();
    t_stall_write();
    t_stall_mode4();
    t_flip_8to4();
    t_flip_4to8();
    finish_up();
  end

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end
endmodule